// File: doc/BRIEF.md
# SGPIO Enclosure LED Serializer

This block keeps the enclosure LED state of a small group of drive ports and sends it to an external LED controller over a three-wire serial link. The lines are a serial clock, a load strobe and a data line. Each drive owns three LEDs: activity, locate and fault. A port-to-slot table decides where in the serial stream each port's three bits appear. The table therefore follows the enclosure wiring, not the port numbering.

An update is a single-cycle message with a port number and a 32-bit state word. The block checks the slot field of the word. It then rewrites the three LED bits of that port and plays out a frame, which has four parts in order:

- a programmable number of idle clocks;
- one clock with the load line high;
- the whole pattern, least significant bit first;
- a programmable number of trailing idle clocks.

Each serial clock period is 50 µs high and then 50 µs low. The number of system clocks per half period comes from a clock-frequency parameter. `busy` is high for the whole frame. Messages that arrive during a frame still update the pattern, and they cause exactly one more frame once the current one ends.

Top module: `sgpio_led_serializer`

## Requirements
- R1: After reset, `ser_clk`, `ser_load` and `ser_data` are all high, `busy` is low and the LED pattern is all zero.
- R2: Port p owns pattern bits 3s, 3s+1 and 3s+2, where s is the 3-bit entry `cfg_slot_map[3p+2:3p]`. Bit 3s is activity, bit 3s+1 is locate and bit 3s+2 is fault.
- R3: An accepted message sets activity when state bit 20 or bit 21 is set, sets locate from state bit 19 and sets fault from state bit 22. A flag that is clear clears its pattern bit. The bits of other ports keep their values.
- R4: The slot field is state bits 11:8. A message whose slot field is 15 or more is rejected: it changes no pattern bit and starts no frame. A slot field of 14 is accepted.
- R5: A frame consists of `cfg_pre` serial clocks, then one serial clock with `ser_load` high, then 3·NUM_PORTS data clocks, then `cfg_post` serial clocks. `ser_load` is low in every other serial clock of the frame. A value of zero gives no padding.
- R6: Data leaves least significant bit first. Each bit is placed on `ser_data` during the low half of the preceding serial clock, and it is stable through the high half of its own clock.
- R7: Each serial clock is high for HALF and then low for HALF system clocks, where HALF = CLK_FREQ_HZ·50/1,000,000. The first serial clock of a frame starts high.
- R8: `busy` stays high for exactly 2·HALF·(frame clocks) system cycles. When `busy` falls, `ser_clk` and `ser_load` are low.
- R9: Messages accepted during a frame do not alter the bits of that frame. After the frame ends, exactly one more frame follows, and it carries the pattern including every such message.
- R10: A message accepted in the final cycle of a frame causes a follow-up frame that carries it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| msg_valid | input | 1 | Single-cycle LED update message strobe |
| msg_port | input | PORT_W | Port the message addresses |
| msg_state | input | 32 | LED state word (flags and slot field) |
| cfg_pre | input | PAD_W | Idle serial clocks before the load clock |
| cfg_post | input | PAD_W | Idle serial clocks after the data bits |
| cfg_slot_map | input | 3·NUM_PORTS | Slot index of each port, 3 bits per port |
| busy | output | 1 | High while a frame is being played out |
| ser_clk | output | 1 | Serial clock to the LED controller |
| ser_load | output | 1 | Load strobe, high for one serial clock per frame |
| ser_data | output | 1 | Serial LED data, least significant bit first |

## Verification
Two functions can fall in the same cycle. One is the message-acceptance path, which updates the pattern and marks a frame as owed. The other is the frame engine, which retires its last low half-period. The bench counts the exact frame length and presents a message on the very clock in which `busy` falls. It then requires the finished frame to be unchanged, and it requires the next frame to carry the new LED bits. A related case sends two messages during a running frame. It is judged by the in-progress bits, by a single follow-up frame that merges both updates, and by the absence of a third frame.

// File: rtl/led_ser_pkg.sv
// Package: shared constants, LED bit bundle type and state-word decoder
// for the SGPIO LED serializer. Assumes a 32-bit message state word.
package led_ser_pkg;
    localparam int STATE_W    = 32;
    localparam int ACT_BIT_A  = 20;
    localparam int ACT_BIT_B  = 21;
    localparam int LOC_BIT    = 19;
    localparam int FLT_BIT    = 22;
    localparam int SLOT_LSB   = 8;
    localparam int SLOT_W     = 4;
    localparam int SLOT_LIMIT = 15;
    localparam int MAP_W      = 3;
    localparam int MAP_MAX    = 8;
    localparam int HALF_US    = 50;

    typedef struct packed {
        logic fault;
        logic locate;
        logic activity;
    } led_bits_t;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_HIGH = 2'd1,
        PH_LOW  = 2'd2
    } phase_e;

    // Turn a state word into the three LED bits of one drive.
    function automatic led_bits_t decode_state(input logic [STATE_W-1:0] s);
        led_bits_t b;
        b.activity = s[ACT_BIT_A] | s[ACT_BIT_B];
        b.locate   = s[LOC_BIT];
        b.fault    = s[FLT_BIT];
        return b;
    endfunction
endpackage

// File: rtl/led_pattern_store.sv
// Pattern store: validates incoming messages (slot field, port range) and
// rewrites the three LED bits at the remapped slot of the addressed port.
// Assumes at most MAP_MAX ports; slot indices >= NUM_PORTS fall outside the
// pattern and update nothing.
module led_pattern_store
    import led_ser_pkg::*;
#(
    parameter int NUM_PORTS = 4,
    parameter int PORT_W    = 2,
    localparam int PAT_W    = 3 * NUM_PORTS
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       msg_valid,
    input  logic [PORT_W-1:0]          msg_port,
    input  logic [STATE_W-1:0]         msg_state,
    input  logic [NUM_PORTS*MAP_W-1:0] slot_map,
    output logic [PAT_W-1:0]           pattern,
    output logic                       accept
);
    logic [SLOT_W-1:0] slot_field;
    logic [MAP_W-1:0]  tgt_slot;
    logic              port_ok;
    led_bits_t         new_bits;

    // Message qualification and slot lookup.
    always_comb begin
        slot_field = msg_state[SLOT_LSB +: SLOT_W];
        port_ok    = ({1'b0, msg_port} < (PORT_W+1)'(NUM_PORTS));
        accept     = msg_valid && port_ok && (int'(slot_field) < SLOT_LIMIT);
        tgt_slot   = slot_map[int'(msg_port)*MAP_W +: MAP_W];
        new_bits   = decode_state(msg_state);
    end

    // Pattern register: write the addressed slot on an accepted message.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pattern <= '0;
        end else if (accept) begin
            for (int s = 0; s < NUM_PORTS; s++) begin
                if (tgt_slot == MAP_W'(s)) begin
                    pattern[3*s +: 3] <= new_bits;
                end
            end
        end
    end
endmodule

// File: rtl/led_half_timer.sv
// Half-period prescaler: while run is high, pulses tick once every HALF_CYC
// system clocks; cleared whenever run is low so each frame starts aligned.
module led_half_timer #(
    parameter int HALF_CYC = 10000,
    localparam int CNT_W   = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    logic [CNT_W-1:0] cnt_q;
    logic             at_end;

    // Terminal count detect.
    always_comb begin
        at_end = (cnt_q == CNT_W'(HALF_CYC - 1));
        tick   = run && at_end;
    end

    // Half-period counter.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt_q <= '0;
        end else if (at_end) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/led_frame_engine.sv
// Frame engine: on start, snapshots the pattern and padding counts, then
// plays pre clocks, one load clock, NBITS data clocks (LSB first) and post
// clocks. Each serial clock is one high and one low half-period, advanced by
// tick. Data changes only on the falling serial edge before its own clock.
module led_frame_engine
    import led_ser_pkg::*;
#(
    parameter int NBITS = 12,
    parameter int PAD_W = 8,
    localparam int IDX_W = $clog2(NBITS + 2) + PAD_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [NBITS-1:0] pattern,
    input  logic [PAD_W-1:0] pre,
    input  logic [PAD_W-1:0] post,
    input  logic             tick,
    output logic             running,
    output logic             ser_clk,
    output logic             ser_load,
    output logic             ser_data
);
    phase_e           phase_q;
    logic [IDX_W-1:0] idx_q;
    logic [NBITS-1:0] shreg_q;
    logic [PAD_W-1:0] pre_q;
    logic [PAD_W-1:0] post_q;
    logic [IDX_W-1:0] pre_x;
    logic [IDX_W-1:0] last_x;
    logic             present_bit;

    // Frame position decode.
    always_comb begin
        running     = (phase_q != PH_IDLE);
        pre_x       = IDX_W'(pre_q);
        last_x      = pre_x + IDX_W'(post_q) + IDX_W'(NBITS);
        present_bit = (idx_q >= pre_x) && (idx_q < pre_x + IDX_W'(NBITS));
    end

    // Frame sequencer and serial line registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q  <= PH_IDLE;
            idx_q    <= '0;
            shreg_q  <= '0;
            pre_q    <= '0;
            post_q   <= '0;
            ser_clk  <= 1'b1;
            ser_load <= 1'b1;
            ser_data <= 1'b1;
        end else begin
            case (phase_q)
                PH_IDLE: begin
                    if (start) begin
                        phase_q  <= PH_HIGH;
                        idx_q    <= '0;
                        shreg_q  <= pattern;
                        pre_q    <= pre;
                        post_q   <= post;
                        ser_clk  <= 1'b1;
                        ser_load <= (pre == '0);
                    end
                end
                PH_HIGH: begin
                    if (tick) begin
                        phase_q <= PH_LOW;
                        ser_clk <= 1'b0;
                        if (present_bit) begin
                            ser_data <= shreg_q[0];
                            shreg_q  <= shreg_q >> 1;
                        end
                    end
                end
                PH_LOW: begin
                    if (tick) begin
                        if (idx_q == last_x) begin
                            phase_q  <= PH_IDLE;
                            ser_load <= 1'b0;
                        end else begin
                            phase_q  <= PH_HIGH;
                            idx_q    <= idx_q + 1'b1;
                            ser_clk  <= 1'b1;
                            ser_load <= ((idx_q + 1'b1) == pre_x);
                        end
                    end
                end
                default: phase_q <= PH_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/sgpio_led_serializer.sv
// Top: SGPIO enclosure LED serializer. Accepts single-cycle LED messages,
// keeps the packed per-slot pattern, and plays one serial frame per burst of
// accepted messages. Assumes cfg_* inputs are static while busy is low and a
// frame is about to start; they are snapshotted at frame start.
module sgpio_led_serializer
    import led_ser_pkg::*;
#(
    parameter int NUM_PORTS   = 4,
    parameter int PAD_W       = 8,
    parameter int CLK_FREQ_HZ = 200_000_000,
    localparam int PORT_W     = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       msg_valid,
    input  logic [PORT_W-1:0]          msg_port,
    input  logic [31:0]                msg_state,
    input  logic [PAD_W-1:0]           cfg_pre,
    input  logic [PAD_W-1:0]           cfg_post,
    input  logic [NUM_PORTS*MAP_W-1:0] cfg_slot_map,
    output logic                       busy,
    output logic                       ser_clk,
    output logic                       ser_load,
    output logic                       ser_data
);
    localparam int    NBITS    = 3 * NUM_PORTS;
    localparam longint HALF_RAW = (longint'(CLK_FREQ_HZ) * HALF_US) / 1_000_000;
    localparam int    HALF_CYC = (HALF_RAW < 1) ? 1 : int'(HALF_RAW);

    logic [NBITS-1:0] pattern;
    logic             accept;
    logic             pend_q;
    logic             start;
    logic             running;
    logic             tick;

    led_pattern_store #(
        .NUM_PORTS(NUM_PORTS),
        .PORT_W   (PORT_W)
    ) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .msg_valid(msg_valid),
        .msg_port (msg_port),
        .msg_state(msg_state),
        .slot_map (cfg_slot_map),
        .pattern  (pattern),
        .accept   (accept)
    );

    // Frame launch: an owed frame starts once the engine is idle.
    always_comb begin
        start = pend_q && !running;
        busy  = running;
    end

    // Owed-frame flag: set by any accepted message, cleared on launch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
        end else begin
            pend_q <= accept | (pend_q & ~start);
        end
    end

    led_half_timer #(
        .HALF_CYC(HALF_CYC)
    ) u_timer (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (running),
        .tick (tick)
    );

    led_frame_engine #(
        .NBITS(NBITS),
        .PAD_W(PAD_W)
    ) u_engine (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .pattern (pattern),
        .pre     (cfg_pre),
        .post    (cfg_post),
        .tick    (tick),
        .running (running),
        .ser_clk (ser_clk),
        .ser_load(ser_load),
        .ser_data(ser_data)
    );
endmodule

// File: rtl/led_serializer_chk.sv
// Checker: temporal properties of the serial link and message handling,
// attached to every sgpio_led_serializer instance by bind.
module led_serializer_chk
    import led_ser_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        msg_valid,
    input logic [31:0] msg_state,
    input logic        pending,
    input logic        busy,
    input logic        ser_clk,
    input logic        ser_load,
    input logic        ser_data
);
    // R7: every frame opens with the serial clock high
    a_r7_start_high: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> ser_clk);

    // R7: serial clock does not move between frames
    a_r7_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !$past(busy)) |-> $stable(ser_clk));

    // R5: the load strobe only rises inside a frame
    a_r5_load_inside: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ser_load) |-> busy);

    // R6: data holds through the high half of a serial clock
    a_r6_data_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy) && ser_clk && $past(ser_clk)) |-> $stable(ser_data));

    // R8: frame ends with clock and load low
    a_r8_end_low: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (!ser_clk && !ser_load));

    // R4: a rejected message while idle starts nothing
    a_r4_reject_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && (int'(msg_state[SLOT_LSB +: SLOT_W]) >= SLOT_LIMIT) && !busy && !pending)
        |=> (!busy && !pending));
endmodule

bind sgpio_led_serializer led_serializer_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .msg_valid(msg_valid),
    .msg_state(msg_state),
    .pending  (pend_q),
    .busy     (busy),
    .ser_clk  (ser_clk),
    .ser_load (ser_load),
    .ser_data (ser_data)
);

// File: tb/tb_sgpio_led_serializer.sv
module tb_sgpio_led_serializer;
    localparam int NP    = 4;
    localparam int NB    = 3 * NP;
    localparam int HALF  = 5;          // 100 kHz * 50 us
    localparam int PADW  = 8;

    typedef struct packed {
        logic [1:0]    port;
        logic [31:0]   state;
        logic [7:0]    pre;
        logic [7:0]    post;
        logic [NB-1:0] pat;
    } vec_t;

    // slot map: port0->2, port1->0, port2->3, port3->1  => 12'h2C2
    localparam vec_t VECS [6] = '{
        '{2'd0, 32'h0010_0000, 8'd0, 8'd0, 12'h040},
        '{2'd1, 32'h0020_0000, 8'd2, 8'd1, 12'h041},
        '{2'd2, 32'h0048_0000, 8'd1, 8'd3, 12'hC41},
        '{2'd3, 32'h0070_0000, 8'd0, 8'd2, 12'hC69},
        '{2'd0, 32'h0008_0000, 8'd3, 8'd0, 12'hCA9},
        '{2'd2, 32'h0000_0300, 8'd0, 8'd0, 12'h0A9}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic msg_valid = 1'b0;
    logic [1:0] msg_port = '0;
    logic [31:0] msg_state = '0;
    logic [PADW-1:0] cfg_pre = '0;
    logic [PADW-1:0] cfg_post = '0;
    logic [NP*3-1:0] cfg_slot_map = 12'h2C2;
    logic busy, ser_clk, ser_load, ser_data;

    int tests = 0;
    int fails = 0;

    always #2.5 clk = ~clk;

    sgpio_led_serializer #(
        .NUM_PORTS(NP), .PAD_W(PADW), .CLK_FREQ_HZ(100_000)
    ) dut (
        .clk(clk), .rst_n(rst_n), .msg_valid(msg_valid), .msg_port(msg_port),
        .msg_state(msg_state), .cfg_pre(cfg_pre), .cfg_post(cfg_post),
        .cfg_slot_map(cfg_slot_map), .busy(busy), .ser_clk(ser_clk),
        .ser_load(ser_load), .ser_data(ser_data)
    );

    // ---------------- frame monitor ----------------
    int   ncyc, blen, hcnt, lcnt;
    bit   hmeas, lmeas, tbad;
    logic w_load [64];
    logic w_dat  [64];
    int   last_ncyc, last_blen;
    bit   last_tbad;
    logic last_load [64];
    logic last_dat  [64];
    int   frames_done = 0;
    int   consumed = 0;
    logic p_busy = 1'b0, p_sclk = 1'b1, p_sload = 1'b1, p_sdata = 1'b1;

    always @(negedge clk) begin
        if (rst_n) begin
            if (busy && !p_busy) begin
                ncyc = 0; blen = 0; tbad = 0; hmeas = 0; lmeas = 0;
            end
            if (busy) blen++;
            if (ser_clk && !p_sclk) begin
                if (lmeas && lcnt != HALF) tbad = 1;
                hcnt = 1; hmeas = busy;
            end else if (ser_clk) begin
                hcnt++;
            end
            if (!ser_clk && p_sclk) begin
                if (hmeas && hcnt != HALF) tbad = 1;
                lcnt = 1; lmeas = 1;
                if (ncyc < 64) begin
                    w_load[ncyc] = p_sload;
                    w_dat[ncyc]  = p_sdata;
                end
                ncyc++;
            end else if (!ser_clk) begin
                lcnt++;
            end
            if (!busy && p_busy) begin
                if (lmeas && lcnt != HALF + 1) tbad = 1;
                lmeas = 0; hmeas = 0;
                last_ncyc = ncyc; last_blen = blen; last_tbad = tbad;
                for (int k = 0; k < 64; k++) begin
                    last_load[k] = w_load[k];
                    last_dat[k]  = w_dat[k];
                end
                frames_done++;
            end
        end
        p_busy = busy; p_sclk = ser_clk; p_sload = ser_load; p_sdata = ser_data;
    end

    // ---------------- helpers ----------------
    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic send(input logic [1:0] p, input logic [31:0] s);
        @(negedge clk);
        msg_port = p; msg_state = s; msg_valid = 1'b1;
        @(negedge clk);
        msg_valid = 1'b0;
    endtask

    task automatic wait_frame();
        wait (frames_done > consumed);
        consumed++;
    endtask

    task automatic check_frame(input int pre, input int post, input logic [NB-1:0] pat, input string tag);
        int n = pre + 1 + NB + post;
        int lbad = 0;
        logic [NB-1:0] got = '0;
        check(last_ncyc == n, {tag, " R5 clock count"}, last_ncyc, n);
        for (int k = 0; k < n && k < 64; k++)
            if (last_load[k] !== (k == pre)) lbad++;
        check(lbad == 0, {tag, " R5 load position"}, lbad, 0);
        for (int j = 0; j < NB; j++) got[j] = last_dat[pre + 1 + j];
        check(got === pat, {tag, " R2 R3 R6 data bits"}, got, pat);
        check(last_blen == 2 * HALF * n, {tag, " R8 busy length"}, last_blen, 2 * HALF * n);
        check(!last_tbad, {tag, " R7 half-period widths"}, last_tbad, 0);
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (200000) @(posedge clk);
        tests++; fails++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    // ---------------- stimulus ----------------
    initial begin
        int seen;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(ser_clk === 1'b1, "R1 ser_clk after reset", ser_clk, 1);
        check(ser_load === 1'b1, "R1 ser_load after reset", ser_load, 1);
        check(ser_data === 1'b1, "R1 ser_data after reset", ser_data, 1);
        check(busy === 1'b0, "R1 busy after reset", busy, 0);

        // Table of vectors: R2 R3 R5 R6 R7 R8
        for (int i = 0; i < 6; i++) begin
            cfg_pre  = VECS[i].pre;
            cfg_post = VECS[i].post;
            send(VECS[i].port, VECS[i].state);
            wait_frame();
            check_frame(int'(VECS[i].pre), int'(VECS[i].post), VECS[i].pat, $sformatf("vec%0d", i));
            @(negedge clk);
            check(!ser_clk && !ser_load, $sformatf("vec%0d R8 lines low after frame", i),
                  {ser_clk, ser_load}, 0);
        end

        // R4: slot field 15 rejected, no frame, no pattern change
        send(2'd0, 32'h0010_0F00);
        seen = 0;
        repeat (30) begin
            @(negedge clk);
            if (busy || ser_clk) seen++;
        end
        check(seen == 0, "R4 rejected message starts no frame", seen, 0);
        // R4: slot field 14 accepted (clears port1 activity); port0 unchanged
        send(2'd1, 32'h0000_0E00);
        wait_frame();
        check_frame(0, 0, 12'h0A8, "R4 slot14");

        // R9: messages during a running frame
        cfg_pre = 8'd2; cfg_post = 8'd2;
        send(2'd3, 32'h0000_0000);
        @(negedge clk);
        check(busy === 1'b1, "R9 frame running", busy, 1);
        send(2'd2, 32'h0040_0000);
        send(2'd1, 32'h0020_0000);
        wait_frame();
        check_frame(2, 2, 12'h080, "R9 in-progress frame");
        wait_frame();
        check_frame(2, 2, 12'h881, "R9 follow-up frame");
        seen = 0;
        repeat (40) begin
            @(negedge clk);
            if (busy) seen++;
        end
        check(seen == 0, "R9 no third frame", seen, 0);

        // R10: message lands in the final cycle of a frame
        cfg_pre = 8'd0; cfg_post = 8'd0;
        send(2'd0, 32'h0000_0000);
        do @(negedge clk); while (!busy);
        repeat (2 * HALF * (NB + 1) - 1) @(negedge clk);
        check(busy === 1'b1, "R10 still in final frame cycle", busy, 1);
        msg_port = 2'd3; msg_state = 32'h0008_0000; msg_valid = 1'b1;
        @(negedge clk);
        msg_valid = 1'b0;
        check(busy === 1'b0, "R10 frame ended on message cycle", busy, 0);
        wait_frame();
        check_frame(0, 0, 12'h801, "R10 ending frame");
        wait_frame();
        check_frame(0, 0, 12'h811, "R10 follow-up frame");

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule